// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Set/Clear Register Writes

This block is a 32-pin general-purpose I/O controller. The pins are split into a low bank (pins 0 to 15) and a high bank (pins 16 to 31). Each bank answers at its own address window, and the high window sits 0x80 above the low one. Each pin has six control bits: output value, output enable, input enable, two output auxiliary selects and one input auxiliary select. Every control register is 16 bits wide, one bit per pin of its bank.

Software never rewrites a control register whole. A 32-bit write carries set requests in bits 15..0 and clear requests in bits 31..16. A zero data bit leaves its pin alone, so several agents can change different pins with no read-modify-write. A read returns the bank's current control bits in bits 15..0, with the upper half zero. A read-only input register gives the pad level of each pin, gated by the pin's input enable.

A pin mask parameter marks which pins exist. The default is 0x0F7FFFFF, which leaves out pins 23 and 28 to 31. Writes to a masked pin are ignored, and the pin reads as 0 in every register.

Top module: `banked_gpio`

## Requirements
- R1: After reset, every control bit is 0. pad_oe and pad_out are all 0, and every register reads 0.
- R2: A write with bit n (n = 0..15) set to 1 and bit n+16 set to 0 sets the addressed control bit of pin n of the addressed bank after the clock edge. Pins whose data bits are both 0 keep their value.
- R3: A write with bit n+16 set to 1 clears the addressed control bit of pin n of the addressed bank.
- R4: If bit n and bit n+16 are both 1 in the same write, the control bit of pin n ends up 0, because clear wins.
- R5: Bank select is address bit 7. Offsets below 0x80 reach pins 0..15, and offsets at 0x80 and above reach pins 16..31. A write to one bank never changes the other bank.
- R6: Register offsets within a bank are fixed: output value 0x00, output enable 0x04, output aux 1 0x10, output aux 2 0x14, input enable 0x20, input aux 1 0x34. Each register is separate from the others. Reads return the 16 pin bits in bits 15..0 and 0 in bits 31..16.
- R7: A read of any other offset returns 0. A write to any other offset changes no state.
- R8: pad_oe[i] equals the output-enable bit of pin i. pad_out[i] equals the output-value bit of pin i when that pin is enabled, and 0 otherwise.
- R9: Offset 0x30 is the read-only input register. It returns pad_in & input-enable for the bank's pins, and writes to it change nothing.
- R10: For pins outside PIN_MASK (default 0x0F7FFFFF), writes are ignored, every register reads 0, and pad_oe and pad_out stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address (bit 7 is the bank, bits 6..0 the offset) |
| bus_wdata | input | 32 | Write data: bits 31..16 clear, bits 15..0 set |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The assertions take for granted that bus_wr, bus_addr and bus_wdata are free of unknown values in every clock cycle from reset onward. They also assume that a write is a single-cycle strobe whose address and data stay steady across the sampling edge. The bench holds all bus inputs at zero from time zero. It changes them only at the falling clock edge and releases the strobe after one rising edge. Because of this, the checks on next-state set, clear and hold behaviour always see defined values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int LANES   = 16;
    localparam int WORD_W  = 32;

    typedef logic [LANES-1:0] lane_t;

    typedef enum logic [2:0] {
        REG_OVAL  = 3'd0,
        REG_OEN   = 3'd1,
        REG_OAUX1 = 3'd2,
        REG_OAUX2 = 3'd3,
        REG_IEN   = 3'd4,
        REG_IAUX1 = 3'd5,
        REG_INVAL = 3'd6,
        REG_NONE  = 3'd7
    } reg_id_t;

    localparam logic [6:0] OFF_OVAL  = 7'h00;
    localparam logic [6:0] OFF_OEN   = 7'h04;
    localparam logic [6:0] OFF_OAUX1 = 7'h10;
    localparam logic [6:0] OFF_OAUX2 = 7'h14;
    localparam logic [6:0] OFF_IEN   = 7'h20;
    localparam logic [6:0] OFF_INVAL = 7'h30;
    localparam logic [6:0] OFF_IAUX1 = 7'h34;

    typedef struct packed {
        lane_t oval;
        lane_t oen;
        lane_t oaux1;
        lane_t oaux2;
        lane_t ien;
        lane_t iaux1;
    } bank_regs_t;

    function automatic lane_t pick_field(bank_regs_t r, reg_id_t id);
        case (id)
            REG_OVAL:  return r.oval;
            REG_OEN:   return r.oen;
            REG_OAUX1: return r.oaux1;
            REG_OAUX2: return r.oaux2;
            REG_IEN:   return r.ien;
            REG_IAUX1: return r.iaux1;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    output reg_id_t              reg_id,
    output logic                 bank_idx,
    output logic [NUM_BANKS-1:0] bank_wr
);
    localparam int OFF_W = ADDR_W - 1;

    logic [OFF_W-1:0] off;

    always_comb begin
        off      = addr[OFF_W-1:0];
        bank_idx = addr[ADDR_W-1];
        case (off)
            OFF_W'(OFF_OVAL):  reg_id = REG_OVAL;
            OFF_W'(OFF_OEN):   reg_id = REG_OEN;
            OFF_W'(OFF_OAUX1): reg_id = REG_OAUX1;
            OFF_W'(OFF_OAUX2): reg_id = REG_OAUX2;
            OFF_W'(OFF_IEN):   reg_id = REG_IEN;
            OFF_W'(OFF_INVAL): reg_id = REG_INVAL;
            OFF_W'(OFF_IAUX1): reg_id = REG_IAUX1;
            default:           reg_id = REG_NONE;
        endcase
        bank_wr = '0;
        if (wr && reg_id != REG_NONE && reg_id != REG_INVAL) begin
            bank_wr[bank_idx] = 1'b1;
        end
    end

    // R5: at most one bank receives any write
    a_r5_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter logic [LANES-1:0] LANE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_id_t           wr_reg,
    input  logic [WORD_W-1:0] wr_data,
    output bank_regs_t        regs_q
);
    bank_regs_t state_d;
    bank_regs_t state_q;
    lane_t      set_m;
    lane_t      clr_m;

    function automatic lane_t apply(lane_t cur, lane_t s, lane_t c);
        return (cur | s) & ~c;
    endfunction

    always_comb begin
        state_d = state_q;
        set_m   = wr_data[LANES-1:0] & LANE_MASK;
        clr_m   = wr_data[WORD_W-1:LANES];
        if (wr_en) begin
            case (wr_reg)
                REG_OVAL:  state_d.oval  = apply(state_q.oval,  set_m, clr_m);
                REG_OEN:   state_d.oen   = apply(state_q.oen,   set_m, clr_m);
                REG_OAUX1: state_d.oaux1 = apply(state_q.oaux1, set_m, clr_m);
                REG_OAUX2: state_d.oaux2 = apply(state_q.oaux2, set_m, clr_m);
                REG_IEN:   state_d.ien   = apply(state_q.ien,   set_m, clr_m);
                REG_IAUX1: state_d.iaux1 = apply(state_q.iaux1, set_m, clr_m);
                default:   state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign regs_q = state_q;

    // R3 / R4: any clear request leaves the addressed bit at 0
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg != REG_NONE && wr_reg != REG_INVAL)
        |=> ((pick_field(state_q, $past(wr_reg)) & $past(wr_data[WORD_W-1:LANES])) == '0));

    // R2: an unopposed set request on an allowed pin leaves the bit at 1
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg != REG_NONE && wr_reg != REG_INVAL)
        |=> ((pick_field(state_q, $past(wr_reg)) & $past(wr_data[LANES-1:0] & ~wr_data[WORD_W-1:LANES] & LANE_MASK))
             == $past(wr_data[LANES-1:0] & ~wr_data[WORD_W-1:LANES] & LANE_MASK)));

    // R7: without a mapped write the bank state holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(state_q));

    // R10: masked pins stay 0 in every register
    a_r10_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.oval | state_q.oen | state_q.oaux1 | state_q.oaux2 |
          state_q.ien | state_q.iaux1) & ~LANE_MASK) == '0);

endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
    import gpio_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] PIN_MASK = 32'h0F7F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe
);
    localparam int NUM_BANKS = 2;
    localparam int PINS      = NUM_BANKS * LANES;

    reg_id_t              reg_id;
    logic                 bank_idx;
    logic [NUM_BANKS-1:0] bank_wr;
    bank_regs_t           regs [NUM_BANKS];
    logic [PINS-1:0]      oval_all;
    logic [PINS-1:0]      oen_all;
    bank_regs_t           sel_regs;
    lane_t                sel_pads;
    lane_t                sel_mask;

    gpio_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .reg_id   (reg_id),
        .bank_idx (bank_idx),
        .bank_wr  (bank_wr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(
            .LANE_MASK (PIN_MASK[b*LANES +: LANES])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[b]),
            .wr_reg  (reg_id),
            .wr_data (bus_wdata),
            .regs_q  (regs[b])
        );
        assign oval_all[b*LANES +: LANES] = regs[b].oval;
        assign oen_all[b*LANES +: LANES]  = regs[b].oen;
    end

    always_comb begin
        pad_oe   = oen_all;
        pad_out  = oval_all & oen_all;
        sel_regs = regs[bank_idx];
        sel_pads = bank_idx ? pad_in[PINS-1:LANES] : pad_in[LANES-1:0];
        sel_mask = bank_idx ? PIN_MASK[PINS-1:LANES] : PIN_MASK[LANES-1:0];
        case (reg_id)
            REG_NONE:  bus_rdata = '0;
            REG_INVAL: bus_rdata = {16'h0, sel_pads & sel_regs.ien & sel_mask};
            default:   bus_rdata = {16'h0, pick_field(sel_regs, reg_id)};
        endcase
    end

    // R8: a pad never shows a 1 unless it is driven
    a_r8_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R10: masked pins never drive
    a_r10_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~PIN_MASK) == '0);

    // R6: upper half of read data is always zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

endmodule

// File: tb/banked_gpio_bench.sv
module banked_gpio_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    banked_gpio u_banked_gpio (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NV = 18;
    localparam logic [79:0] VEC [NV] = '{
        {8'h00, 32'h0000_00A5, 8'h00, 32'h0000_00A5}, // R2
        {8'h00, 32'h0000_0100, 8'h00, 32'h0000_01A5}, // R2 others kept
        {8'h00, 32'h0005_0000, 8'h00, 32'h0000_01A0}, // R3
        {8'h00, 32'h0020_0040, 8'h00, 32'h0000_01C0}, // R2 R3 mixed
        {8'h00, 32'h0080_0080, 8'h00, 32'h0000_0140}, // R4
        {8'h04, 32'h0000_FFFF, 8'h04, 32'h0000_FFFF}, // R6
        {8'h10, 32'h0000_1234, 8'h10, 32'h0000_1234}, // R6
        {8'h14, 32'h0000_8001, 8'h14, 32'h0000_8001}, // R6
        {8'h20, 32'h0000_00F0, 8'h20, 32'h0000_00F0}, // R6
        {8'h34, 32'h0000_0F0F, 8'h34, 32'h0000_0F0F}, // R6
        {8'h14, 32'h0000_0000, 8'h10, 32'h0000_1234}, // R6 separate
        {8'h80, 32'h0000_FFFF, 8'h80, 32'h0000_0F7F}, // R5 R10
        {8'h84, 32'h0000_FFFF, 8'h84, 32'h0000_0F7F}, // R5 R10
        {8'h80, 32'h0000_0000, 8'h00, 32'h0000_0140}, // R5 low kept
        {8'h08, 32'h0000_FFFF, 8'h08, 32'h0000_0000}, // R7
        {8'h88, 32'h0000_FFFF, 8'h88, 32'h0000_0000}, // R7
        {8'h80, 32'hFFFF_0000, 8'h80, 32'h0000_0000}, // R3 high
        {8'h08, 32'h0000_FFFF, 8'h04, 32'h0000_FFFF}  // R7 no side effect
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        read_check("R1 oval", 8'h00, 32'h0);
        read_check("R1 ien hi", 8'hA0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            write(VEC[i][79:72], VEC[i][71:40]);
            read_check($sformatf("vec%0d R2/R3/R4/R5/R6/R7/R10", i), VEC[i][39:32], VEC[i][31:0]);
        end

        // R8 pads: low oval 0x0140 oen 0xFFFF; high oval 0 oen 0x0F7F
        #1;
        check("R8 pad_oe", pad_oe, 32'h0F7F_FFFF);
        check("R8 pad_out", pad_out, 32'h0000_0140);
        write(8'h80, 32'h0000_FFFF);
        #1;
        check("R8 R10 pad_out hi", pad_out, 32'h0F7F_0140);
        write(8'h04, 32'h0040_0000);
        #1;
        check("R8 pad_oe cleared", pad_oe, 32'h0F7F_FFBF);
        check("R8 pad_out gated", pad_out, 32'h0F7F_0100);

        // R9 input register
        pad_in = 32'hFFFF_FFFF;
        read_check("R9 low in", 8'h30, 32'h0000_00F0);
        read_check("R9 high in disabled", 8'hB0, 32'h0);
        write(8'hA0, 32'h0000_FFFF);
        read_check("R9 R10 high in", 8'hB0, 32'h0000_0F7F);
        pad_in = 32'h0000_0055;
        read_check("R9 low in level", 8'h30, 32'h0000_0050);
        write(8'h30, 32'hFFFF_FFFF);
        read_check("R9 write ignored in", 8'h30, 32'h0000_0050);
        read_check("R9 write ignored ien", 8'h20, 32'h0000_00F0);

        // R10 reserved pin 23 and 28..31 on output value
        write(8'h80, 32'h0000_0000);
        read_check("R10 oval hi", 8'h80, 32'h0000_0F7F);

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        read_check("R1 oen after reset", 8'h04, 32'h0);
        read_check("R1 aux after reset", 8'h94, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule